// File: doc/BRIEF.md
# Checksummed Serial Command Responder

This block stands in for a remote-controlled media player on a serial link. A byte-wide receive handshake delivers each character decoded by an external UART. The link runs at 9600 baud with one start bit, eight data bits, odd parity and one stop bit. Every accepted byte is pushed into an eleven-byte sliding window, and the oldest byte falls out. After every push the window is tested as a command frame. A frame needs two sync bytes of 0xFF in the two oldest slots and the address byte 0x21 in the third-oldest slot. The seven-bit sum of all eleven bytes must also be zero.

A valid frame arms a fixed eleven-byte answer: FF FE 7F 7E 7D 7C 7B 7A 79 78 77. The bytes are handed one at a time to an external UART transmitter over a byte-wide handshake. A programmable gap timer, nominally 100 ms, comes before every answer byte. The first gap starts at frame detection. Each later gap starts when the transmitter reports that the previous byte has finished. When the gap expires, a byte is issued only if answer bytes remain and the transmitter reports idle. Otherwise that slot is lost.

The modem status lines are held inactive and the idle level of the serial output is reported high.

Top module: `serial_cmd_responder`

## Requirements
- R1: Each byte accepted with `rx_valid` becomes the newest window entry and the oldest of the eleven is discarded. Detection depends only on the last eleven bytes, so bytes received earlier have no effect.
- R2: Frame validity needs the oldest window byte and the next-oldest byte to both be 0xFF, and the third-oldest byte to be 0x21. A frame with any other value in these three positions produces no reply.
- R3: Frame validity also needs the sum of all eleven bytes, taken modulo 128, to be zero. Bit 7 of the checksum byte therefore does not matter. A checksum that is off by one produces no reply.
- R4: The reply is the byte sequence FF, FE, 7F, 7E, 7D, 7C, 7B, 7A, 79, 78, 77, in that order. Each reply byte is a single-cycle `tx_valid` pulse, with the byte on `tx_data`.
- R5: The first reply byte is issued exactly DELAY_CYC+3 clock cycles after the clock edge that accepts the last byte of a valid frame.
- R6: Each later reply byte is issued exactly DELAY_CYC+1 clock cycles after the edge that samples a `tx_done` pulse.
- R7: When the gap expires, a byte is issued only if fewer than 11 bytes have been sent and `tx_ready` is high. A skipped slot leaves the byte position unchanged. After the eleventh byte, `tx_done` causes no further output.
- R8: After reset the window holds zeros and the reply position is 11, so no reply is pending and `tx_done` alone produces no output.
- R9: `carrier_det`, `set_ready`, `ring_ind` and `clr_send` are always 0, and `line_idle` is always 1.
- R10: A valid frame that completes while a reply is in progress restarts the reply from its first byte (FF), on the R5 schedule.
- R11: DELAY_CYC equals CLK_HZ / 1000 * GAP_MS, so the gap length follows the clock-frequency and gap parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter is idle and can accept a byte |
| tx_done | input | 1 | One-cycle strobe: the transmitter finished a byte |
| tx_valid | output | 1 | One-cycle strobe: `tx_data` holds a reply byte |
| tx_data | output | 8 | Reply byte |
| carrier_det | output | 1 | Carrier detect status, always 0 |
| set_ready | output | 1 | Data-set-ready status, always 0 |
| ring_ind | output | 1 | Ring indicator status, always 0 |
| clr_send | output | 1 | Clear-to-send status, always 0 |
| line_idle | output | 1 | Idle level of the serial output, always 1 |

## Verification
The first reply byte arrives exactly DELAY_CYC+3 cycles after the edge that accepts the last frame byte. These cycles come from the window register, the registered match flag, the timer load and the registered expiry. Every later byte arrives DELAY_CYC+1 cycles after the edge that samples `tx_done`. The bench shortens DELAY_CYC to 8 and counts falling edges from the accepting edge. It records the first cycle in which `tx_valid` is seen and compares that cycle and `tx_data` with these exact latencies. For cases that must produce no reply, it watches `tx_valid` for several cycles past the latest cycle a byte could be due.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [7:0] ADDR_BYTE = 8'h21;
  localparam int         CK_BITS   = 7;

  // Answer byte k: FF, FE, then descending from 7F.
  function automatic logic [7:0] answer_byte(input logic [7:0] k);
    logic [7:0] r;
    case (k)
      8'd0:    r = 8'hFF;
      8'd1:    r = 8'hFE;
      default: r = 8'h81 - k;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rsp_window.sv
module rsp_window #(
  parameter int LEN = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       frame_hit
);
  import rsp_pkg::*;

  logic [7:0] win_q [LEN];
  logic       fresh_q;
  logic [CK_BITS-1:0] ck_sum;
  logic       match;

  // Slot 0 is the oldest byte, slot LEN-1 the newest.
  for (genvar g = 0; g < LEN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        win_q[g] <= '0;
      end else if (rx_valid) begin
        if (g == LEN - 1) win_q[g] <= rx_data;
        else              win_q[g] <= win_q[g+1];
      end
    end
  end

  always_comb begin
    ck_sum = '0;
    for (int i = 0; i < LEN; i++) ck_sum = ck_sum + win_q[i][CK_BITS-1:0];
  end

  assign match = (win_q[0] == SYNC_BYTE) && (win_q[1] == SYNC_BYTE) &&
                 (win_q[2] == ADDR_BYTE) && (ck_sum == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q   <= 1'b0;
      frame_hit <= 1'b0;
    end else begin
      fresh_q   <= rx_valid;
      frame_hit <= fresh_q && match;
    end
  end
endmodule

// File: rtl/rsp_gap_timer.sv
module rsp_gap_timer #(
  parameter int DELAY_CYC = 8,
  localparam int CNT_W    = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= !start && (cnt_q == CNT_W'(1));
      if (start)              cnt_q <= CNT_W'(DELAY_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rsp_sequencer.sv
module rsp_sequencer #(
  parameter int LEN = 11,
  localparam int IDX_W = $clog2(LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             fire,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic [IDX_W-1:0] idx
);
  import rsp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= IDX_W'(LEN);
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (hit) begin
      idx      <= '0;
      tx_valid <= 1'b0;
    end else if (fire && (idx < IDX_W'(LEN)) && tx_ready) begin
      tx_valid <= 1'b1;
      tx_data  <= answer_byte(8'(idx));
      idx      <= idx + 1'b1;
    end else begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_cmd_responder.sv
module serial_cmd_responder #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int GAP_MS    = 100,
  parameter int FRAME_LEN = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  input  logic       tx_done,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       carrier_det,
  output logic       set_ready,
  output logic       ring_ind,
  output logic       clr_send,
  output logic       line_idle
);
  localparam int DELAY_CYC = CLK_HZ / 1000 * GAP_MS;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);

  logic             frame_hit;
  logic             timer_fire;
  logic [IDX_W-1:0] reply_idx;

  rsp_window #(.LEN(FRAME_LEN)) u_window (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .frame_hit(frame_hit)
  );

  rsp_gap_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(frame_hit || tx_done), .fire(timer_fire)
  );

  rsp_sequencer #(.LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst(rst), .hit(frame_hit), .fire(timer_fire),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .idx(reply_idx)
  );

  assign carrier_det = 1'b0;
  assign set_ready   = 1'b0;
  assign ring_ind    = 1'b0;
  assign clr_send    = 1'b0;
  assign line_idle   = 1'b1;
endmodule

// File: rtl/serial_cmd_responder_chk.sv
module serial_cmd_responder_chk #(
  parameter int IDX_W = 4,
  parameter int LEN   = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             frame_hit,
  input logic             timer_fire,
  input logic [IDX_W-1:0] reply_idx
);
  // R7: a byte leaves only after a gap expiry with the transmitter idle
  p_send_gated_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ($past(tx_ready) && $past(timer_fire)));

  // R7: position never passes the reply length
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    reply_idx <= IDX_W'(LEN));

  // R10: a detected frame rewinds the reply
  p_hit_rewinds_r10: assert property (@(posedge clk) disable iff (rst)
    frame_hit |=> (reply_idx == '0));

  // R4: each issued byte advances the position by one
  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (reply_idx == $past(reply_idx) + 1'b1));

  // R4: strobes last one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  // R4: the first byte of a reply is the sync value
  p_first_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && reply_idx == IDX_W'(1)) |-> (tx_data == 8'hFF));
endmodule

bind serial_cmd_responder serial_cmd_responder_chk #(.IDX_W(IDX_W), .LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .frame_hit(frame_hit), .timer_fire(timer_fire),
  .reply_idx(reply_idx)
);

// File: tb/serial_cmd_responder_bench.sv
module serial_cmd_responder_bench;
  localparam int CLK_HZ = 8000;
  localparam int GAP_MS = 1;
  localparam int D      = CLK_HZ / 1000 * GAP_MS;   // R11: 8 cycles
  localparam int NVEC   = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_ready = 1'b1;
  logic       tx_done = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       carrier_det, set_ready, ring_ind, clr_send, line_idle;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serial_cmd_responder #(.CLK_HZ(CLK_HZ), .GAP_MS(GAP_MS)) u_serial_cmd_responder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_valid(tx_valid),
    .tx_data(tx_data), .carrier_det(carrier_det), .set_ready(set_ready),
    .ring_ind(ring_ind), .clr_send(clr_send), .line_idle(line_idle)
  );

  // {byte0..byte9, checksum offset, reply expected}
  localparam logic [88:0] VEC [NVEC] = '{
    {80'hFFFF213E407000000000, 8'h00, 1'b1},   // R2 R3 good frame
    {80'hFFFF210C437500000000, 8'h01, 1'b0},   // R3 checksum off by one
    {80'hFFFF210C502000000000, 8'h80, 1'b1},   // R3 bit 7 of checksum ignored
    {80'hFFFE210C446000000000, 8'h00, 1'b0},   // R2 second sync wrong
    {80'hFFFF220C506100000000, 8'h00, 1'b0},   // R2 address wrong
    {80'hFEFF213E406000000000, 8'h00, 1'b0}    // R2 first sync wrong
  };

  function automatic logic [7:0] expect_byte(input int k);
    if (k == 0) return 8'hFF;
    if (k == 1) return 8'hFE;
    return 8'(8'h81 - k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rx_valid = 1'b0; tx_done = 1'b0; tx_ready = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Sends ten bytes plus a computed checksum (+ offset). Returns at the
  // falling edge right after the edge that accepted the last byte.
  task automatic send_frame(input logic [79:0] head, input logic [7:0] off);
    logic [6:0] s;
    s = '0;
    for (int i = 0; i < 10; i++) begin
      s = s + head[79-8*i -: 7'd7 + 1'd1];
      send_byte(head[79-8*i -: 8]);
    end
    send_byte(8'({1'b0, 7'(7'h00 - s)}) + off);
  endtask

  // Counts falling edges until tx_valid is seen (0 when not seen within lim).
  task automatic wait_tx(input int lim, output int lat, output logic [7:0] d);
    lat = 0; d = '0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (tx_valid && lat == 0) begin lat = k; d = tx_data; end
      if (lat != 0) break;
    end
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat;
    logic [7:0] d;

    // R8 R9: reset state
    do_reset();
    check("R8 tx_valid after reset", tx_valid, 0);
    check("R9 carrier_det", carrier_det, 0);
    check("R9 set_ready", set_ready, 0);
    check("R9 ring_ind", ring_ind, 0);
    check("R9 clr_send", clr_send, 0);
    check("R9 line_idle", line_idle, 1);
    pulse_done();
    wait_tx(D + 6, lat, d);
    check("R8 no reply pending after reset", lat, 0);

    // Table walk: R2 R3 R5
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      send_frame(VEC[v][88:9], VEC[v][8:1]);
      wait_tx(D + 6, lat, d);
      if (VEC[v][0]) begin
        check("R5 first byte latency", lat, D + 3);
        check("R4 first byte value", d, 8'hFF);
      end else begin
        check("R2/R3 rejected frame gives no reply", lat, 0);
      end
    end

    // R4 R6 R7: full reply, then nothing more
    do_reset();
    send_frame(80'hFFFF210C446000000000, 8'h00);
    wait_tx(D + 6, lat, d);
    check("R5 latency", lat, D + 3);
    check("R4 byte 0", d, expect_byte(0));
    for (int k = 1; k < 11; k++) begin
      pulse_done();
      wait_tx(D + 6, lat, d);
      check("R6 gap after tx_done", lat, D + 1);
      check("R4 reply byte", d, expect_byte(k));
    end
    pulse_done();
    wait_tx(D + 6, lat, d);
    check("R7 nothing after eleventh byte", lat, 0);

    // R1: leading junk bytes slide out of the window
    do_reset();
    send_byte(8'h12); send_byte(8'hFF); send_byte(8'h21);
    send_frame(80'hFFFF213E407000000000, 8'h00);
    wait_tx(D + 6, lat, d);
    check("R1 frame after junk latency", lat, D + 3);
    check("R1 frame after junk byte", d, 8'hFF);

    // R7: transmitter busy at expiry skips the slot, position kept
    do_reset();
    tx_ready = 1'b0;
    send_frame(80'hFFFF213E407000000000, 8'h00);
    wait_tx(D + 6, lat, d);
    check("R7 busy transmitter gets no byte", lat, 0);
    tx_ready = 1'b1;
    pulse_done();
    wait_tx(D + 6, lat, d);
    check("R7 retry latency", lat, D + 1);
    check("R7 skipped byte kept", d, 8'hFF);

    // R10: new frame mid-reply restarts from byte 0
    do_reset();
    send_frame(80'hFFFF213E407000000000, 8'h00);
    wait_tx(D + 6, lat, d);
    pulse_done();
    wait_tx(D + 6, lat, d);
    check("R10 second byte before restart", d, 8'hFE);
    send_frame(80'hFFFF210C437500000000, 8'h00);
    wait_tx(D + 6, lat, d);
    check("R10 restart latency", lat, D + 3);
    check("R10 restart byte", d, 8'hFF);
    pulse_done();
    wait_tx(D + 6, lat, d);
    check("R10 continues with second byte", d, 8'hFE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule